// File: doc/BRIEF.md
# Synchronous Character Hunt Detector

This block finds character alignment in a serial bit stream for byte-oriented synchronous reception. While it hunts, every bit is shifted into a window register. The most recent 6, 8, 12 or 16 bits of that window are compared with a programmed sync pattern. In external mode, a strobe on a dedicated input sets the alignment instead. Once aligned, the block assembles characters of 5 to 8 bits. It discards sync characters that come before the first real character, and from then on it delivers every character with a one-cycle valid strobe.

Sync characters of 5 or 7 bits need no extra compare width. Software programs the 8- or 16-bit pattern with the short character repeated and overlapped, and the window match then lands on the boundary of the last complete repetition. A re-hunt command drops alignment at any time and restarts the search from an empty window.

The control is a three-state machine:
- `ST_HUNT` searches for the pattern or the external strobe.
- `ST_STRIP` discards leading sync characters.
- `ST_DATA` delivers every character.

Its transitions are:
- pattern hit: `ST_HUNT` to `ST_STRIP`.
- external align: `ST_HUNT` to `ST_DATA`.
- sync char dropped: `ST_STRIP` to `ST_STRIP`.
- first data char: `ST_STRIP` to `ST_DATA`.
- re-hunt: any state to `ST_HUNT`.

Top module: `sync_hunt_detector`

## Requirements
- R1: After reset `in_sync`, `sync_found` and `data_valid` are 0 and the block is hunting.
- R2: With `sync_sel`=0 the newest 6 received bits are compared with `sync_pattern[5:0]`; with `sync_sel`=1 the newest 8 bits are compared with `sync_pattern[7:0]`. The newest bit is compared with pattern bit 0, and the oldest bit of the window with the top compared bit. Higher pattern bits are ignored.
- R3: With `sync_sel`=2 the newest 12 bits are compared with `sync_pattern[11:0]`; with `sync_sel`=3 the newest 16 bits are compared with `sync_pattern[15:0]`.
- R4: A hit counts only when at least the compared number of bits has been received since hunting began. On a hit, `sync_found` pulses for one cycle and `in_sync` rises, both in the cycle after the bit edge that completed the match.
- R5: When `sync_sel[2]`=1 (external mode), a bit edge with `ext_sync`=1 while hunting sets alignment: that bit is dropped, `sync_found` pulses, `in_sync` rises and no characters are stripped. The pattern is not used in this mode. `ext_sync` has no effect in the pattern modes.
- R6: Character length is `char_len`+5 bits (codes 0..3 give 5..8). Counting starts with the bit after the alignment edge, and the first received bit becomes the most significant bit of the character. `data_out` is right-aligned with its upper bits 0. `data_valid` pulses in the cycle after the bit edge of the character's last bit.
- R7: After a pattern hit, each complete character equal to `sync_pattern` bits [L-1:0] (L = character length) is discarded, up to the first character that differs.
- R8: After the first character has been delivered, characters equal to the sync character are delivered as data.
- R9: A 5-bit sync character repeated in the stream is found by the 8-bit compare when the pattern holds the newest 8 bits of that repetition. Alignment falls after the last complete repetition.
- R10: `hunt_req`=1 has priority over every other input. `in_sync` is 0 in the following cycle, no output pulses for that edge, and the window and its bit count are cleared.
- R11: Cycles with `bit_en`=0 shift no bit, count no bit and produce no `sync_found` or `data_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit enable; `rx_bit` is taken on edges where it is 1 |
| rx_bit | input | 1 | Serial receive data |
| sync_sel | input | 3 | 0 mono 6, 1 mono 8, 2 bi 12, 3 bi 16, 4..7 external |
| char_len | input | 2 | Character length code, length = code + 5 |
| sync_pattern | input | 16 | Sync pattern, compared from bit 0 upward |
| ext_sync | input | 1 | External alignment strobe (external mode only) |
| hunt_req | input | 1 | Drop alignment and hunt again |
| in_sync | output | 1 | Character alignment held |
| sync_found | output | 1 | One-cycle pulse when alignment is set |
| data_valid | output | 1 | One-cycle pulse with a delivered character |
| data_out | output | 8 | Delivered character, right-aligned |

## Verification
The bench attacks the fill rule with an all-zero pattern straight after a re-hunt. A window that ignores its bit count would declare alignment on the first zero instead of the eighth. The 12-bit case is preceded by bits that differ from the upper pattern nibble, so a design comparing too many bits never aligns. A repeated sync character after real data must come out as data, and one before real data must not; an off-by-one in the bit count shows up as shifted characters in the scoreboard. The external strobe is tried in a pattern mode, where it must do nothing, and in external mode, where its own bit must be dropped and no sync-equal character may be stripped.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_STRIP = 2'd1,
        ST_DATA  = 2'd2
    } hunt_state_t;

    localparam logic [2:0] SEL_MONO6 = 3'd0;
    localparam logic [2:0] SEL_MONO8 = 3'd1;
    localparam logic [2:0] SEL_BI12  = 3'd2;

    // Number of pattern bits compared for a select code.
    function automatic logic [4:0] window_bits(input logic [2:0] sel);
        logic [4:0] w;
        case (sel)
            SEL_MONO6: w = 5'd6;
            SEL_MONO8: w = 5'd8;
            SEL_BI12:  w = 5'd12;
            default:   w = 5'd16;
        endcase
        return w;
    endfunction

    // Character length in bits for a length code.
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return {2'b00, code} + 4'd5;
    endfunction

    function automatic logic is_external(input logic [2:0] sel);
        return sel[2];
    endfunction

endpackage

// File: rtl/sync_window.sv
module sync_window #(
    parameter int WIN_W = 16,
    localparam int FILL_W = $clog2(WIN_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              rx_bit,
    input  logic [WIN_W-1:0]  pattern,
    input  logic [FILL_W-1:0] width,
    output logic              hit
);

    logic [WIN_W-1:0]  win_q;
    logic [WIN_W-1:0]  win_nx;
    logic [WIN_W-1:0]  mask;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_nx;

    // One compare-enable bit per window position.
    for (genvar g = 0; g < WIN_W; g++) begin : g_mask
        assign mask[g] = (g < int'(width));
    end

    always_comb begin
        win_nx  = {win_q[WIN_W-2:0], rx_bit};
        fill_nx = (fill_q == FILL_W'(WIN_W)) ? fill_q : fill_q + 1'b1;
        hit     = shift && (fill_nx >= width)
                  && (((win_nx ^ pattern) & mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (shift) begin
            win_q  <= win_nx;
            fill_q <= fill_nx;
        end
    end

endmodule

// File: rtl/char_assembler.sv
module char_assembler #(
    parameter int CHAR_MAX = 8,
    localparam int CNT_W = $clog2(CHAR_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                run,
    input  logic                rx_bit,
    input  logic [CNT_W-1:0]    len,
    input  logic [CHAR_MAX-1:0] ref_char,
    output logic                done,
    output logic [CHAR_MAX-1:0] value,
    output logic                is_ref
);

    logic [CHAR_MAX-1:0] sr_q;
    logic [CHAR_MAX-1:0] shifted;
    logic [CHAR_MAX-1:0] mask;
    logic [CNT_W-1:0]    cnt_q;

    for (genvar g = 0; g < CHAR_MAX; g++) begin : g_mask
        assign mask[g] = (g < int'(len));
    end

    always_comb begin
        shifted = {sr_q[CHAR_MAX-2:0], rx_bit};
        value   = shifted & mask;
        done    = run && (cnt_q == (len - CNT_W'(1)));
        is_ref  = (value == (ref_char & mask));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (run) begin
            sr_q  <= shifted;
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hunt_fsm.sv
module hunt_fsm
    import sync_hunt_pkg::*;
#(
    parameter int CHAR_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                hunt_req,
    input  logic                ext_mode,
    input  logic                ext_sync,
    input  logic                hit,
    input  logic                char_done,
    input  logic                char_is_sync,
    input  logic [CHAR_MAX-1:0] char_val,
    output hunt_state_t         state_q,
    output logic                align,
    output logic                in_sync,
    output logic                sync_found,
    output logic                data_valid,
    output logic [CHAR_MAX-1:0] data_out
);

    hunt_state_t state_nx;
    logic        deliver;

    always_comb begin
        align    = 1'b0;
        deliver  = 1'b0;
        state_nx = state_q;
        if (hunt_req) begin
            state_nx = ST_HUNT;                          // re-hunt
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (bit_en && ext_mode && ext_sync) begin
                        align    = 1'b1;
                        state_nx = ST_DATA;              // external align
                    end else if (bit_en && !ext_mode && hit) begin
                        align    = 1'b1;
                        state_nx = ST_STRIP;             // pattern hit
                    end
                end
                ST_STRIP: begin
                    if (char_done && !char_is_sync) begin
                        deliver  = 1'b1;
                        state_nx = ST_DATA;              // first data char
                    end
                end
                ST_DATA: begin
                    deliver = char_done;
                end
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync    <= 1'b0;
            sync_found <= 1'b0;
            data_valid <= 1'b0;
            data_out   <= '0;
        end else begin
            in_sync    <= (state_nx != ST_HUNT);
            sync_found <= align;
            data_valid <= deliver;
            if (deliver) data_out <= char_val;
        end
    end

endmodule

// File: rtl/sync_hunt_detector.sv
module sync_hunt_detector
    import sync_hunt_pkg::*;
#(
    parameter int WIN_W    = 16,
    parameter int CHAR_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                rx_bit,
    input  logic [2:0]          sync_sel,
    input  logic [1:0]          char_len,
    input  logic [WIN_W-1:0]    sync_pattern,
    input  logic                ext_sync,
    input  logic                hunt_req,
    output logic                in_sync,
    output logic                sync_found,
    output logic                data_valid,
    output logic [CHAR_MAX-1:0] data_out
);

    localparam int FILL_W = $clog2(WIN_W + 1);
    localparam int CNT_W  = $clog2(CHAR_MAX + 1);

    hunt_state_t         state;
    logic                in_hunt;
    logic                ext_mode;
    logic                win_shift;
    logic                hit;
    logic                align;
    logic                asm_clr;
    logic                asm_run;
    logic                char_done;
    logic                char_is_sync;
    logic [CHAR_MAX-1:0] char_val;
    logic [FILL_W-1:0]   width_sel;
    logic [CNT_W-1:0]    len_sel;

    always_comb begin
        ext_mode  = is_external(sync_sel);
        width_sel = FILL_W'(window_bits(sync_sel));
        len_sel   = CNT_W'(char_bits(char_len));
        in_hunt   = (state == ST_HUNT);
        win_shift = in_hunt && bit_en && !hunt_req && !ext_mode;
        asm_run   = !in_hunt && bit_en && !hunt_req;
        asm_clr   = hunt_req || align;
    end

    sync_window #(.WIN_W(WIN_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hunt_req),
        .shift   (win_shift),
        .rx_bit  (rx_bit),
        .pattern (sync_pattern),
        .width   (width_sel),
        .hit     (hit)
    );

    char_assembler #(.CHAR_MAX(CHAR_MAX)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (asm_clr),
        .run      (asm_run),
        .rx_bit   (rx_bit),
        .len      (len_sel),
        .ref_char (sync_pattern[CHAR_MAX-1:0]),
        .done     (char_done),
        .value    (char_val),
        .is_ref   (char_is_sync)
    );

    hunt_fsm #(.CHAR_MAX(CHAR_MAX)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .hunt_req     (hunt_req),
        .ext_mode     (ext_mode),
        .ext_sync     (ext_sync),
        .hit          (hit),
        .char_done    (char_done),
        .char_is_sync (char_is_sync),
        .char_val     (char_val),
        .state_q      (state),
        .align        (align),
        .in_sync      (in_sync),
        .sync_found   (sync_found),
        .data_valid   (data_valid),
        .data_out     (data_out)
    );

endmodule

// File: rtl/sync_hunt_checker.sv
module sync_hunt_checker #(
    parameter int CHAR_MAX = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_en,
    input logic                hunt_req,
    input logic [1:0]          char_len,
    input logic                in_sync,
    input logic                sync_found,
    input logic                data_valid,
    input logic [CHAR_MAX-1:0] data_out
);

    p_hunt_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |=> (!in_sync && !sync_found && !data_valid));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!sync_found && !data_valid));

    p_found_in_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |-> in_sync);

    p_rise_announced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> sync_found);

    p_found_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |=> !sync_found);

    p_valid_in_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> in_sync);

    p_len5_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(char_len) == 2'd0) |-> ((data_out >> 5) == '0));

endmodule

bind sync_hunt_detector sync_hunt_checker #(.CHAR_MAX(CHAR_MAX)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .hunt_req   (hunt_req),
    .char_len   (char_len),
    .in_sync    (in_sync),
    .sync_found (sync_found),
    .data_valid (data_valid),
    .data_out   (data_out)
);

// File: tb/tb_sync_hunt_detector.sv
module tb_sync_hunt_detector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic [2:0]  sync_sel = 3'd1;
    logic [1:0]  char_len = 2'd3;
    logic [15:0] sync_pattern = 16'h0016;
    logic        ext_sync = 1'b0;
    logic        hunt_req = 1'b0;
    logic        in_sync;
    logic        sync_found;
    logic        data_valid;
    logic [7:0]  data_out;

    int vectors = 0;
    int errors  = 0;
    int sf_seen = 0;
    int dv_seen = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    sync_hunt_detector dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .rx_bit       (rx_bit),
        .sync_sel     (sync_sel),
        .char_len     (char_len),
        .sync_pattern (sync_pattern),
        .ext_sync     (ext_sync),
        .hunt_req     (hunt_req),
        .in_sync      (in_sync),
        .sync_found   (sync_found),
        .data_valid   (data_valid),
        .data_out     (data_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Monitor: pops expected characters as the design delivers them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sync_found) sf_seen++;
            if (data_valid) begin
                dv_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7/R8 unexpected character", int'(data_out), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(data_out == e, "R6 scoreboard character", int'(data_out), int'(e));
                end
            end
        end
    end

    task automatic send_bit(input logic b, input logic ext);
        @(negedge clk);
        rx_bit   = b;
        ext_sync = ext;
        bit_en   = 1'b1;
        @(negedge clk);
        bit_en   = 1'b0;
        ext_sync = 1'b0;
        #1;
    endtask

    task automatic send_char(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i], 1'b0);
    endtask

    task automatic hunt_cmd();
        @(negedge clk);
        hunt_req = 1'b1;
        @(negedge clk);
        hunt_req = 1'b0;
        #1;
    endtask

    task automatic queue_empty(input string req);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        int sf0;
        int dv0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!in_sync, "R1 in_sync after reset", in_sync, 0);
        chk(!sync_found && !data_valid, "R1 pulses after reset",
            {sync_found, data_valid}, 0);

        // R2/R7/R8: mono 8-bit, prefix noise, stripping, later sync passes
        sf0 = sf_seen;
        send_bit(1, 0); send_bit(1, 0); send_bit(1, 0);
        exp_q.push_back(8'hA5); exp_q.push_back(8'h16); exp_q.push_back(8'h3C);
        send_char(16'h16, 8);
        chk(in_sync, "R2 mono8 aligned", in_sync, 1);
        chk(sf_seen == sf0 + 1, "R4 sync_found pulse count", sf_seen - sf0, 1);
        send_char(16'h16, 8);
        send_char(16'hA5, 8);
        send_char(16'h16, 8);
        send_char(16'h3C, 8);
        queue_empty("R8 sync-equal char after data delivered");

        // R11: idle cycles with toggling data count nothing
        dv0 = dv_seen;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_bit = ~rx_bit;
        end
        #1;
        chk(dv_seen == dv0, "R11 no output while bit_en low", dv_seen - dv0, 0);
        exp_q.push_back(8'h7E);
        send_char(16'h7E, 8);
        queue_empty("R11 character intact after idle");

        // R10: re-hunt with a concurrent bit edge
        sf0 = sf_seen;
        dv0 = dv_seen;
        @(negedge clk);
        hunt_req = 1'b1; bit_en = 1'b1; rx_bit = 1'b1;
        @(negedge clk);
        hunt_req = 1'b0; bit_en = 1'b0;
        #1;
        chk(!in_sync, "R10 in_sync cleared", in_sync, 0);
        chk(sf_seen == sf0 && dv_seen == dv0, "R10 no pulse on hunt edge",
            (sf_seen - sf0) + (dv_seen - dv0), 0);

        // R4: all-zero pattern needs a full window after re-hunt
        sync_pattern = 16'h0000;
        sf0 = sf_seen;
        send_char(16'h0, 7);
        chk(!in_sync, "R4 no hit before window filled", in_sync, 0);
        send_bit(0, 0);
        chk(in_sync, "R4 hit when window filled", in_sync, 1);
        chk(sf_seen == sf0 + 1, "R4 one sync_found", sf_seen - sf0, 1);
        exp_q.push_back(8'h81);
        send_char(16'h00, 8);
        send_char(16'h81, 8);
        queue_empty("R7 zero sync stripped");
        hunt_cmd();

        // R5: ext_sync ignored in a pattern mode
        sync_pattern = 16'h0016;
        send_bit(0, 1);
        chk(!in_sync, "R5 ext_sync ignored in mono8", in_sync, 0);
        hunt_cmd();

        // R2: mono 6-bit, upper pattern bits ignored
        sync_sel = 3'd0; char_len = 2'd1; sync_pattern = 16'hFF1A;
        sf0 = sf_seen;
        exp_q.push_back(8'h2A);
        send_char(16'h1A, 6);
        chk(in_sync, "R2 mono6 aligned", in_sync, 1);
        send_char(16'h1A, 6);
        send_char(16'h2A, 6);
        chk(sf_seen == sf0 + 1, "R2 mono6 single sync", sf_seen - sf0, 1);
        queue_empty("R7 mono6 strip then data");
        hunt_cmd();

        // R3: bi-sync 16
        sync_sel = 3'd3; char_len = 2'd3; sync_pattern = 16'hEB90;
        exp_q.push_back(8'h55); exp_q.push_back(8'h90);
        send_char(16'hEB, 8);
        chk(!in_sync, "R3 bi16 not aligned on half pattern", in_sync, 0);
        send_char(16'h90, 8);
        chk(in_sync, "R3 bi16 aligned", in_sync, 1);
        send_char(16'h90, 8);
        send_char(16'h55, 8);
        send_char(16'h90, 8);
        queue_empty("R3 bi16 data");
        hunt_cmd();

        // R3: bi-sync 12, prefix differs from upper pattern nibble
        sync_sel = 3'd2; char_len = 2'd1; sync_pattern = 16'h3A5C;
        exp_q.push_back(8'h33);
        send_char(16'hC, 4);
        send_char(16'hA5C, 12);
        chk(in_sync, "R3 bi12 aligned on 12 bits", in_sync, 1);
        send_char(16'h1C, 6);
        send_char(16'h33, 6);
        queue_empty("R3 bi12 data");
        hunt_cmd();

        // R9: 5-bit sync repeated, matched by 8-bit window
        sync_sel = 3'd1; char_len = 2'd0; sync_pattern = 16'h00D6;
        send_char(16'h16, 5);
        chk(!in_sync, "R9 no hit after one repetition", in_sync, 0);
        send_char(16'h16, 5);
        chk(in_sync, "R9 aligned after second repetition", in_sync, 1);
        exp_q.push_back(8'h09);
        send_char(16'h16, 5);
        send_char(16'h09, 5);
        queue_empty("R9 5-bit data");
        hunt_cmd();

        // R5: external mode
        sync_sel = 3'd4; char_len = 2'd3; sync_pattern = 16'h00C3;
        send_char(16'hC3, 8);
        chk(!in_sync, "R5 pattern unused in external mode", in_sync, 0);
        sf0 = sf_seen;
        send_bit(1, 1);
        chk(in_sync, "R5 external align", in_sync, 1);
        chk(sf_seen == sf0 + 1, "R5 external sync_found", sf_seen - sf0, 1);
        exp_q.push_back(8'hC3); exp_q.push_back(8'h5A);
        send_char(16'hC3, 8);
        send_char(16'h5A, 8);
        queue_empty("R5 no strip in external mode");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule